// File: doc/BRIEF.md
# Prioritized Interrupt and Sleep Controller

This block sits beside a small 8-bit processor core and decides, at each point where the core may be interrupted, whether an interrupt is taken, which one, and where the core must fetch its handler address. Six sources compete. The first is a non-maskable request, which is edge-detected and latched. The other five are level requests: an external maskable line, the timer's capture, compare and overflow requests, and a serial-port request. The serial request is built from the port's enable and status bits. Every source except the non-maskable one is blocked by the core's interrupt mask flag.

The controller also owns the two low-power states of the core. A sleep command idles the core until any source is pending, whether masked or not. A wait command first has the core push its registers, then idles until an unmasked source arrives. An interrupt taken out of wait skips the stacking step and reports a fixed stall count instead. Instruction execution and the memory writes of stacking are left to the core. Only the handshakes are modelled here: a take strobe with vector, a stacking request, stacking completion, and a set-mask strobe.

Top module: `irq_sleep_ctrl`

## Requirements
- R1: When the core signals an instruction boundary (boundary_i high) and a source may be taken, take_o pulses for one cycle in the following cycle. The winner is chosen in the fixed order non-maskable, external, capture, compare, overflow, serial, with the first listed winning.
- R2: vector_o, valid while take_o is high, is FFFC for the non-maskable source, FFF8 for external, FFF6 for capture, FFF4 for compare, FFF2 for overflow and FFF0 for serial.
- R3: While mask_i is high, no source other than the non-maskable one is taken.
- R4: The serial source requests when rx_en_i is high with rx_full_i or rx_ovr_i high, or when tx_en_i is high with tx_empty_i high. Status bits without their enable do not request.
- R5: In sleep, any pending source ends sleep, including a masked one. A masked source returns mode_o to run without a take. An unmasked source is also taken.
- R6: A sleep command checks sources in the same cycle. It enters sleep only if nothing is pending. An unmasked pending source is taken at once, and a masked one leaves the block in run.
- R7: A wait command pulses stack_o with take_o low in the next cycle, and mode_o reads wait. After stack_done_i, an unmasked pending source is taken; otherwise the block idles in wait. Only an unmasked source ends wait.
- R8: A take out of wait has stack_o low and stall_o equal to 4. Any other take has stack_o high, asking for the program counter, index register, both accumulators and the condition code to be pushed, and stall_o equal to 0.
- R9: A pulse on rti_done_i, marking the end of a return from interrupt, checks sources in the same way as a boundary does.
- R10: A rising edge on nmi_i sets a pending latch, which clears when the non-maskable interrupt is taken. A level held high causes no second take.
- R11: set_mask_o is high in exactly the cycles in which take_o is high.
- R12: After reset, take_o, stack_o and set_mask_o are low and mode_o is 0. mode_o encodes run as 0, sleep as 1 and wait as 2, including the stacking phase of wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| ext_irq_i | input | 1 | External maskable request, level |
| cap_irq_i | input | 1 | Timer capture request |
| cmp_irq_i | input | 1 | Timer compare request |
| ovf_irq_i | input | 1 | Timer overflow request |
| rx_en_i | input | 1 | Serial receive interrupt enable |
| rx_full_i | input | 1 | Serial receive data full |
| rx_ovr_i | input | 1 | Serial overrun or framing error |
| tx_en_i | input | 1 | Serial transmit interrupt enable |
| tx_empty_i | input | 1 | Serial transmit register empty |
| mask_i | input | 1 | Core interrupt mask flag |
| boundary_i | input | 1 | Core is at an instruction boundary |
| rti_done_i | input | 1 | Return from interrupt has completed |
| sleep_cmd_i | input | 1 | Sleep instruction issued |
| wait_cmd_i | input | 1 | Wait instruction issued |
| stack_done_i | input | 1 | Core finished the requested register push |
| take_o | output | 1 | Interrupt taken strobe |
| vector_o | output | 16 | Vector address of the taken interrupt |
| stack_o | output | 1 | Request to push all registers |
| stall_o | output | 3 | Stall cycles reported with the take |
| set_mask_o | output | 1 | Set the core's mask flag |
| mode_o | output | 2 | 0 run, 1 sleep, 2 wait |

## Verification
The hardest case to reach is a masked source that arrives while the core sleeps. It must end sleep without producing a take, and the only visible trace is mode_o falling back to run. The stimulus puts the block to sleep with nothing pending, then raises the mask and a timer request together. Next to it, the bench checks the counterpart in wait: the same masked request leaves the block in wait until the mask drops. That take must then show the wait-specific stall and no stacking, including the case where the source was already pending before the stacking handshake finished.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned NSRC  = 6;
  localparam int unsigned VEC_W = 16;

  localparam int unsigned SRC_NMI = 0;
  localparam int unsigned SRC_EXT = 1;
  localparam int unsigned SRC_CAP = 2;
  localparam int unsigned SRC_CMP = 3;
  localparam int unsigned SRC_OVF = 4;
  localparam int unsigned SRC_SER = 5;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WSTACK = 2'd2,
    ST_WAIT   = 2'd3
  } ctl_state_e;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_WAIT  = 2'd2;

  // non-maskable at top of table, then descending even addresses from FFF8
  function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx);
    logic [31:0] v;
    if (idx == 0) v = 32'h0000_FFFC;
    else          v = 32'h0000_FFFA - 32'(2 * idx);
    return v[VEC_W-1:0];
  endfunction
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_o <= rise | (pend_o & ~clr_i);
    end
  end

  assert_nmi_latch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise) |=> !pend_o);

  assert_nmi_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> pend_o);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC,
  parameter int unsigned VW    = VEC_W
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic             mask_i,
  output logic             any_o,
  output logic             elig_any_o,
  output logic             nmi_sel_o,
  output logic [VW-1:0]    vec_o
);
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] grant;
  logic [VW-1:0]    vec_tab [N_SRC];

  // index 0 is the non-maskable source
  assign elig = req_i & ~{{(N_SRC-1){mask_i}}, 1'b0};

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_vec
      assign vec_tab[gi] = src_vector(gi);
    end
  endgenerate

  always_comb begin
    grant = '0;
    vec_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        vec_o    = vec_tab[i];
      end
    end
  end

  assign any_o      = |req_i;
  assign elig_any_o = |elig;
  assign nmi_sel_o  = grant[0];

  always_comb begin
    assert_grant_onehot_R1: assert ($onehot0(grant));
  end
endmodule

// File: rtl/irq_ctl_fsm.sv
module irq_ctl_fsm
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned VW         = VEC_W,
  parameter int unsigned STALL_W    = 3,
  parameter int unsigned WAIT_STALL = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pend_any_i,
  input  logic               takeable_i,
  input  logic               sel_nmi_i,
  input  logic [VW-1:0]      sel_vec_i,
  input  logic               boundary_i,
  input  logic               rti_done_i,
  input  logic               sleep_cmd_i,
  input  logic               wait_cmd_i,
  input  logic               stack_done_i,
  output logic               take_o,
  output logic [VW-1:0]      vec_o,
  output logic               stack_o,
  output logic [STALL_W-1:0] stall_o,
  output logic               set_mask_o,
  output logic               take_nmi_o,
  output logic [1:0]         mode_o
);
  localparam logic [STALL_W-1:0] WSTALL = STALL_W'(WAIT_STALL);

  ctl_state_e         state_q, state_d;
  logic               take_d, stack_d;
  logic [STALL_W-1:0] stall_d;

  always_comb begin
    state_d = state_q;
    take_d  = 1'b0;
    stack_d = 1'b0;
    stall_d = '0;
    unique case (state_q)
      ST_RUN: begin
        if (wait_cmd_i) begin
          state_d = ST_WSTACK;
          stack_d = 1'b1;
        end else if (sleep_cmd_i) begin
          if (!pend_any_i) state_d = ST_SLEEP;
          else if (takeable_i) begin
            take_d  = 1'b1;
            stack_d = 1'b1;
          end
        end else if ((boundary_i || rti_done_i) && takeable_i) begin
          take_d  = 1'b1;
          stack_d = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (pend_any_i) begin
          state_d = ST_RUN;
          if (takeable_i) begin
            take_d  = 1'b1;
            stack_d = 1'b1;
          end
        end
      end
      ST_WSTACK: begin
        if (stack_done_i) begin
          if (takeable_i) begin
            take_d  = 1'b1;
            stall_d = WSTALL;
            state_d = ST_RUN;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (takeable_i) begin
          take_d  = 1'b1;
          stall_d = WSTALL;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign take_nmi_o = take_d & sel_nmi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      take_o  <= 1'b0;
      stack_o <= 1'b0;
      stall_o <= '0;
      vec_o   <= '0;
    end else begin
      state_q <= state_d;
      take_o  <= take_d;
      stack_o <= stack_d;
      stall_o <= stall_d;
      if (take_d) vec_o <= sel_vec_i;
    end
  end

  assign set_mask_o = take_o;

  always_comb begin
    unique case (state_q)
      ST_SLEEP:           mode_o = MODE_SLEEP;
      ST_WSTACK, ST_WAIT: mode_o = MODE_WAIT;
      default:            mode_o = MODE_RUN;
    endcase
  end

  assert_sleep_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && pend_any_i) |=> (state_q != ST_SLEEP));

  assert_wait_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && wait_cmd_i) |=> (stack_o && !take_o && mode_o == MODE_WAIT));

  assert_wait_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT || state_q == ST_WSTACK) && takeable_i && (state_q == ST_WAIT || stack_done_i))
      |=> (take_o && !stack_o && stall_o == WSTALL));
endmodule

// File: rtl/irq_sleep_ctrl.sv
module irq_sleep_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned STALL_W    = 3,
  parameter int unsigned WAIT_STALL = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               nmi_i,
  input  logic               ext_irq_i,
  input  logic               cap_irq_i,
  input  logic               cmp_irq_i,
  input  logic               ovf_irq_i,
  input  logic               rx_en_i,
  input  logic               rx_full_i,
  input  logic               rx_ovr_i,
  input  logic               tx_en_i,
  input  logic               tx_empty_i,
  input  logic               mask_i,
  input  logic               boundary_i,
  input  logic               rti_done_i,
  input  logic               sleep_cmd_i,
  input  logic               wait_cmd_i,
  input  logic               stack_done_i,
  output logic               take_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               stack_o,
  output logic [STALL_W-1:0] stall_o,
  output logic               set_mask_o,
  output logic [1:0]         mode_o
);
  logic             nmi_pend, nmi_clr;
  logic             ser_req;
  logic [NSRC-1:0]  req;
  logic             any_pend, takeable, sel_nmi;
  logic [VEC_W-1:0] sel_vec;

  assign ser_req = (rx_en_i & (rx_full_i | rx_ovr_i)) | (tx_en_i & tx_empty_i);

  always_comb begin
    req          = '0;
    req[SRC_NMI] = nmi_pend;
    req[SRC_EXT] = ext_irq_i;
    req[SRC_CAP] = cap_irq_i;
    req[SRC_CMP] = cmp_irq_i;
    req[SRC_OVF] = ovf_irq_i;
    req[SRC_SER] = ser_req;
  end

  irq_nmi_edge u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  irq_prio_sel #(.N_SRC(NSRC), .VW(VEC_W)) u_sel (
    .req_i      (req),
    .mask_i     (mask_i),
    .any_o      (any_pend),
    .elig_any_o (takeable),
    .nmi_sel_o  (sel_nmi),
    .vec_o      (sel_vec)
  );

  irq_ctl_fsm #(.VW(VEC_W), .STALL_W(STALL_W), .WAIT_STALL(WAIT_STALL)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_any_i   (any_pend),
    .takeable_i   (takeable),
    .sel_nmi_i    (sel_nmi),
    .sel_vec_i    (sel_vec),
    .boundary_i   (boundary_i),
    .rti_done_i   (rti_done_i),
    .sleep_cmd_i  (sleep_cmd_i),
    .wait_cmd_i   (wait_cmd_i),
    .stack_done_i (stack_done_i),
    .take_o       (take_o),
    .vec_o        (vector_o),
    .stack_o      (stack_o),
    .stall_o      (stall_o),
    .set_mask_o   (set_mask_o),
    .take_nmi_o   (nmi_clr),
    .mode_o       (mode_o)
  );

  assert_mask_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vector_o != src_vector(SRC_NMI)) |-> !$past(mask_i));

  assert_serial_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && vector_o == src_vector(SRC_SER)) |-> $past(ser_req));
endmodule

// File: tb/irq_sleep_ctrl_tb.sv
module irq_sleep_ctrl_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic nmi_i = 0, ext_irq_i = 0, cap_irq_i = 0, cmp_irq_i = 0, ovf_irq_i = 0;
  logic rx_en_i = 0, rx_full_i = 0, rx_ovr_i = 0, tx_en_i = 0, tx_empty_i = 0;
  logic mask_i = 0, boundary_i = 0, rti_done_i = 0;
  logic sleep_cmd_i = 0, wait_cmd_i = 0, stack_done_i = 0;
  logic        take_o, stack_o, set_mask_o;
  logic [15:0] vector_o;
  logic [2:0]  stall_o;
  logic [1:0]  mode_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] vec;
    logic        stk;
    logic [2:0]  stall;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  irq_sleep_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic expect_take(input logic [15:0] v, input logic s, input logic [2:0] st);
    exp_t e;
    e.vec = v; e.stk = s; e.stall = st;
    exp_q.push_back(e);
  endtask

  task automatic bnd();
    boundary_i = 1; tick(); boundary_i = 0; tick();
  endtask

  task automatic bnd_none(input string tag);
    boundary_i = 1; tick();
    chk(take_o == 0, tag, take_o, 0);
    boundary_i = 0; tick();
  endtask

  // scoreboard monitor: R1/R2/R8 content, R11 set-mask pairing
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (take_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected take: vec=%h expected none", vector_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (vector_o !== e.vec || stack_o !== e.stk || stall_o !== e.stall || set_mask_o !== 1'b1) begin
            errors++;
            $display("FAIL R2/R8/R11 take: vec=%h stack=%0d stall=%0d setmask=%0d expected vec=%h stack=%0d stall=%0d setmask=1",
                     vector_o, stack_o, stall_o, set_mask_o, e.vec, e.stk, e.stall);
          end
        end
      end else if (set_mask_o) begin
        checks++; errors++;
        $display("FAIL R11 set_mask without take: actual=1 expected=0");
      end
    end
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1; tick();
    // R12 reset state
    chk(take_o == 0 && stack_o == 0 && set_mask_o == 0, "R12 idle outputs", take_o, 0);
    chk(mode_o == 2'd0, "R12 mode", mode_o, 0);

    // R1 R2 single external
    ext_irq_i = 1; expect_take(16'hFFF8, 1, 0); bnd(); ext_irq_i = 0;

    // R1 priority ladder with all sources active
    cap_irq_i = 1; cmp_irq_i = 1; ovf_irq_i = 1; rx_en_i = 1; rx_full_i = 1; ext_irq_i = 1;
    nmi_i = 1; tick(); nmi_i = 0;
    expect_take(16'hFFFC, 1, 0); bnd();
    expect_take(16'hFFF8, 1, 0); bnd(); ext_irq_i = 0;
    expect_take(16'hFFF6, 1, 0); bnd(); cap_irq_i = 0;
    expect_take(16'hFFF4, 1, 0); bnd(); cmp_irq_i = 0;
    expect_take(16'hFFF2, 1, 0); bnd(); ovf_irq_i = 0;
    expect_take(16'hFFF0, 1, 0); bnd(); rx_full_i = 0; rx_en_i = 0;
    bnd_none("R1 nothing pending");

    // R3 mask
    mask_i = 1; cap_irq_i = 1;
    bnd_none("R3 masked capture");
    nmi_i = 1; tick(); nmi_i = 0;
    expect_take(16'hFFFC, 1, 0); bnd();
    mask_i = 0; expect_take(16'hFFF6, 1, 0); bnd(); cap_irq_i = 0;

    // R4 serial combinations
    rx_full_i = 1; bnd_none("R4 full without enable");
    rx_en_i = 1; expect_take(16'hFFF0, 1, 0); bnd();
    rx_full_i = 0; rx_ovr_i = 1; expect_take(16'hFFF0, 1, 0); bnd();
    rx_ovr_i = 0; bnd_none("R4 enable without status");
    rx_en_i = 0; tx_empty_i = 1; bnd_none("R4 empty without enable");
    tx_en_i = 1; expect_take(16'hFFF0, 1, 0); bnd();
    tx_en_i = 0; tx_empty_i = 0;

    // R6 sleep with nothing pending, R5 masked wake
    sleep_cmd_i = 1; tick(); sleep_cmd_i = 0;
    chk(mode_o == 2'd1, "R6 sleep entered", mode_o, 1);
    boundary_i = 1; tick(); boundary_i = 0;
    chk(mode_o == 2'd1, "R6 sleep holds", mode_o, 1);
    mask_i = 1; ovf_irq_i = 1; tick();
    chk(mode_o == 2'd0, "R5 masked source ends sleep", mode_o, 0);
    chk(take_o == 0, "R5 masked source not taken", take_o, 0);
    ovf_irq_i = 0; mask_i = 0; tick();

    // R5 unmasked wake with take
    sleep_cmd_i = 1; tick(); sleep_cmd_i = 0;
    chk(mode_o == 2'd1, "R5 sleep entered", mode_o, 1);
    ovf_irq_i = 1; expect_take(16'hFFF2, 1, 0); tick();
    chk(mode_o == 2'd0, "R5 woke to run", mode_o, 0);
    ovf_irq_i = 0; tick();

    // R6 sleep command with pending source
    mask_i = 1; cmp_irq_i = 1;
    sleep_cmd_i = 1; tick(); sleep_cmd_i = 0;
    chk(mode_o == 2'd0 && take_o == 0, "R6 masked pending blocks sleep", mode_o, 0);
    mask_i = 0; expect_take(16'hFFF4, 1, 0);
    sleep_cmd_i = 1; tick(); sleep_cmd_i = 0;
    chk(mode_o == 2'd0, "R6 immediate take stays run", mode_o, 0);
    cmp_irq_i = 0; tick();

    // R7 wait with nothing pending, R8 take out of wait
    wait_cmd_i = 1; tick(); wait_cmd_i = 0;
    chk(stack_o == 1 && take_o == 0, "R7 stack request first", stack_o, 1);
    chk(mode_o == 2'd2, "R7 wait mode", mode_o, 2);
    tick();
    chk(stack_o == 0 && mode_o == 2'd2, "R7 awaiting stack done", mode_o, 2);
    stack_done_i = 1; tick(); stack_done_i = 0;
    chk(mode_o == 2'd2 && take_o == 0, "R7 idles in wait", mode_o, 2);
    mask_i = 1; ext_irq_i = 1; tick(); tick();
    chk(mode_o == 2'd2, "R7 masked source keeps wait", mode_o, 2);
    mask_i = 0; expect_take(16'hFFF8, 0, 4); tick();
    chk(mode_o == 2'd0, "R8 wait exit to run", mode_o, 0);
    ext_irq_i = 0; tick();

    // R7 R8 wait with source already pending
    cap_irq_i = 1;
    wait_cmd_i = 1; tick(); wait_cmd_i = 0;
    chk(stack_o == 1 && take_o == 0, "R7 stacking before check", stack_o, 1);
    stack_done_i = 1; expect_take(16'hFFF6, 0, 4); tick(); stack_done_i = 0;
    chk(mode_o == 2'd0, "R8 run after wait take", mode_o, 0);
    cap_irq_i = 0; tick();

    // R9 return-from-interrupt recheck
    ovf_irq_i = 1; tick(); tick();
    chk(take_o == 0, "R9 no take without check point", take_o, 0);
    expect_take(16'hFFF2, 1, 0);
    rti_done_i = 1; tick(); rti_done_i = 0; tick();
    ovf_irq_i = 0;

    // R10 edge latch
    nmi_i = 1; tick();
    expect_take(16'hFFFC, 1, 0); bnd();
    bnd_none("R10 held level no retake");
    nmi_i = 0; tick();
    nmi_i = 1; tick(); nmi_i = 0;
    expect_take(16'hFFFC, 1, 0); bnd();
    bnd_none("R10 latch cleared");

    repeat (4) tick();
    chk(exp_q.size() == 0, "R1 all expected takes seen", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule